// File: doc/BRIEF.md
# SMBus Alert Responder

This block is the device side of the SMBus alert mechanism. It owns one pin that either carries an ordinary push-pull output or serves as the open-drain alert line. In alert mode the pin is pulled low while an internal service request is present and the alert has been armed. The alert is armed by a host write that clears an active-low enable bit.

The block watches the bus clock and data lines through synchronizers and detects START and STOP. It recognizes the alert response read, the byte `0001100` followed by a read bit of 1. While its alert is pending, it acknowledges that byte and then shifts its own 7-bit address onto SDA, most significant bit first. SDA is open-drain, so several alerting devices answering at once resolve by wired-AND arbitration. A device that releases SDA for a 1 but samples a 0 withdraws. The device that sends its whole address unopposed sets its enable bit, which drops its alert. The losers keep their alerts raised for a later response cycle, so devices are served lowest address first.

Top module: `alert_responder`

## Requirements
- R1: With `modeAlert`=0 the pin is a push-pull output: `pinOe`=1 and `pinOut` follows `gpOut` one clock later. The request input and the enable bit have no effect on the pin.
- R2: With `modeAlert`=1, `pinOut` is 0 and `pinOe` is 1 (pin pulled low) exactly when `enableN`=0 and `alertReq`=1, one clock after those inputs.
- R3: `enableN` resets to 1. A cycle with `enWrStb`=1 loads it from `enWrData`. Only a host write can bring it to 0.
- R4: After a START, the first 8 bits sampled on rising SCL are compared with the byte 0x19 (`0001100` plus read bit 1). On a match with the alert pending (`modeAlert`=1, `enableN`=0, `alertReq`=1), SDA is pulled low for the ninth clock. Any other byte gets no acknowledge.
- R5: After the acknowledge, the block presents its parameter address `OWN_ADDR` on SDA for the next 7 clocks, MSB first: SDA is released for a 1 and pulled low for a 0. It leaves the eighth bit and the master's acknowledge bit released.
- R6: If all 7 address bits go out without losing arbitration, `enableN` becomes 1 and the alert pin is released. It stays released, even with `alertReq` held, until the host writes `enableN` to 0 again.
- R7: When the alert is not pending, the block never drives SDA, so the alert response byte reads no acknowledge.
- R8: If SDA reads 0 on rising SCL while the block is releasing SDA for a 1, the block stops driving for the rest of the transfer. It leaves `enableN` at 0 and keeps its alert asserted. Among several pending devices, the lowest address is returned and only that device releases.
- R9: A STOP (SDA rising while SCL high) at any point returns the block to idle with SDA released. A START at any point restarts address reception.
- R10: The block begins pulling SDA low only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock level as seen at the pad |
| sdaIn | input | 1 | Bus data level as seen at the pad |
| sdaPullLow | output | 1 | 1 pulls SDA low, 0 releases it |
| modeAlert | input | 1 | Pin function: 1 alert line, 0 general output |
| gpOut | input | 1 | General output level used when `modeAlert`=0 |
| alertReq | input | 1 | Internal service request |
| enWrStb | input | 1 | Host write strobe for the enable bit |
| enWrData | input | 1 | Value written into the enable bit |
| enableN | output | 1 | Current active-low alert enable bit |
| pinOe | output | 1 | Pin output enable |
| pinOut | output | 1 | Pin driven level when enabled |

## Verification
Three devices with distinct addresses share a modeled wired-AND data line driven by a bench master. A lone pending device answering the alert response byte shows the acknowledge, the address bits and the release. The same byte with no device pending, and near-miss bytes such as the write form of the address, separate pending-gated acknowledge from address decode. With all three armed, repeated response cycles must return the addresses in ascending order, releasing one device per cycle, which tells arbitration loss apart from completion. A STOP placed mid-address checks that the block returns to idle with its alert still raised. General-output mode toggles `gpOut` while the alert is armed to show that the pin ignores the alert path.

// File: rtl/alert_resp_pkg.sv
package alert_resp_pkg;

  localparam int ADDR_W = 7;
  localparam logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RXADDR,
    ST_ACKWAIT,
    ST_ACK,
    ST_TX,
    ST_SKIP
  } respState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic rxShift;
    logic txLoad;
    logic txShift;
    logic driveAck;
    logic driveTx;
    logic releaseAlert;
  } ctrlStb_t;

  // conditions from datapath to control
  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
    logic sdaLvl;
    logic rxIsAra;
    logic cntRxLast;
    logic cntTxLast;
    logic txBit;
    logic pending;
  } dpStat_t;

endpackage

// File: rtl/alert_resp_dp.sv
module alert_resp_dp
  import alert_resp_pkg::*;
#(
  parameter logic [ADDR_W-1:0] OWN_ADDR = 7'h2C,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclIn,
  input  logic     sdaIn,
  input  logic     modeAlert,
  input  logic     gpOut,
  input  logic     alertReq,
  input  logic     enWrStb,
  input  logic     enWrData,
  input  ctrlStb_t stb,
  output dpStat_t  stat,
  output logic     sclSync,
  output logic     sdaPullLow,
  output logic     enableN,
  output logic     pinOe,
  output logic     pinOut
);

  localparam int CNT_W = $clog2(ADDR_W + 1);

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclS, sdaS, sclD, sdaD;
  logic [CNT_W-1:0] bitCnt;
  logic [ADDR_W:0] rxByte;
  logic [ADDR_W:0] rxNext;
  logic [ADDR_W-1:0] txReg;
  logic [ADDR_W-1:0] txNext;
  logic pending;

  // bus line synchronizers, idle level high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];
  assign sclSync = sclS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  // bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (stb.cntClr) bitCnt <= '0;
    else if (stb.cntInc) bitCnt <= bitCnt + 1'b1;
  end

  // receive shifter
  assign rxNext = {rxByte[ADDR_W-1:0], sdaS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxByte <= '0;
    else if (stb.rxShift) rxByte <= rxNext;
  end

  // transmit shifter, fills with released bits
  always_comb begin
    txNext = txReg;
    if (stb.txLoad) txNext = OWN_ADDR;
    else if (stb.txShift) txNext = {txReg[ADDR_W-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txReg <= '1;
    else txReg <= txNext;
  end

  // active-low enable bit: hardware release wins over host write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enableN <= 1'b1;
    else if (stb.releaseAlert) enableN <= 1'b1;
    else if (enWrStb) enableN <= enWrData;
  end

  assign pending = modeAlert & ~enableN & alertReq;

  // SDA driver uses the post-shift bit so it moves one clock after the SCL fall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sdaPullLow <= 1'b0;
    else sdaPullLow <= stb.driveAck | (stb.driveTx & ~txNext[ADDR_W-1]);
  end

  // pin function mux
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinOe  <= 1'b0;
      pinOut <= 1'b0;
    end else if (modeAlert) begin
      pinOe  <= pending;
      pinOut <= 1'b0;
    end else begin
      pinOe  <= 1'b1;
      pinOut <= gpOut;
    end
  end

  always_comb begin
    stat.start     = sclS & sclD & sdaD & ~sdaS;
    stat.stop      = sclS & sclD & ~sdaD & sdaS;
    stat.sclRise   = sclS & ~sclD;
    stat.sclFall   = ~sclS & sclD;
    stat.sdaLvl    = sdaS;
    stat.rxIsAra   = (rxNext == {ARA_ADDR, 1'b1});
    stat.cntRxLast = (bitCnt == CNT_W'(ADDR_W));
    stat.cntTxLast = (bitCnt == CNT_W'(ADDR_W - 1));
    stat.txBit     = txReg[ADDR_W-1];
    stat.pending   = pending;
  end

endmodule

// File: rtl/alert_resp_ctrl.sv
module alert_resp_ctrl
  import alert_resp_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  dpStat_t  stat,
  output ctrlStb_t stb
);

  respState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNext;
  end

  always_comb begin
    stb = '0;
    stateNext = state;
    if (stat.stop) begin
      stateNext = ST_IDLE;
    end else if (stat.start) begin
      stateNext = ST_RXADDR;
      stb.cntClr = 1'b1;
    end else begin
      case (state)
        ST_RXADDR: begin
          if (stat.sclRise) begin
            stb.rxShift = 1'b1;
            if (stat.cntRxLast) begin
              stateNext = (stat.rxIsAra && stat.pending) ? ST_ACKWAIT : ST_SKIP;
            end else begin
              stb.cntInc = 1'b1;
            end
          end
        end
        ST_ACKWAIT: begin
          if (stat.sclFall) begin
            stb.driveAck = 1'b1;
            stateNext = ST_ACK;
          end
        end
        ST_ACK: begin
          stb.driveAck = 1'b1;
          if (stat.sclFall) begin
            stb.txLoad = 1'b1;
            stb.cntClr = 1'b1;
            stateNext = ST_TX;
          end
        end
        ST_TX: begin
          stb.driveTx = 1'b1;
          if (stat.sclRise) begin
            if (stat.txBit && !stat.sdaLvl) begin
              stateNext = ST_SKIP;
            end else if (stat.cntTxLast) begin
              stb.releaseAlert = 1'b1;
            end
          end else if (stat.sclFall) begin
            if (stat.cntTxLast) begin
              stb.driveTx = 1'b0;
              stateNext = ST_SKIP;
            end else begin
              stb.cntInc = 1'b1;
              stb.txShift = 1'b1;
            end
          end
        end
        default: begin
          stateNext = state;
        end
      endcase
    end
  end

endmodule

// File: rtl/alert_responder.sv
module alert_responder
  import alert_resp_pkg::*;
#(
  parameter logic [ADDR_W-1:0] OWN_ADDR = 7'h2C,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaPullLow,
  input  logic modeAlert,
  input  logic gpOut,
  input  logic alertReq,
  input  logic enWrStb,
  input  logic enWrData,
  output logic enableN,
  output logic pinOe,
  output logic pinOut
);

  ctrlStb_t stb;
  dpStat_t  stat;
  logic     sclSync;

  alert_resp_ctrl ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .stat (stat),
    .stb  (stb)
  );

  alert_resp_dp #(
    .OWN_ADDR    (OWN_ADDR),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .modeAlert  (modeAlert),
    .gpOut      (gpOut),
    .alertReq   (alertReq),
    .enWrStb    (enWrStb),
    .enWrData   (enWrData),
    .stb        (stb),
    .stat       (stat),
    .sclSync    (sclSync),
    .sdaPullLow (sdaPullLow),
    .enableN    (enableN),
    .pinOe      (pinOe),
    .pinOut     (pinOut)
  );

endmodule

// File: rtl/alert_responder_chk.sv
module alert_responder_chk (
  input logic clk,
  input logic rstN,
  input logic modeAlert,
  input logic gpOut,
  input logic alertReq,
  input logic enWrStb,
  input logic enWrData,
  input logic enableN,
  input logic pinOe,
  input logic pinOut,
  input logic sdaPullLow,
  input logic sclSync
);

  logic seen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seen <= 1'b0;
    else seen <= 1'b1;
  end

  AST_GP_PIN: assert property (@(posedge clk) disable iff (!rstN)
    (seen && !$past(modeAlert)) |-> (pinOe && (pinOut == $past(gpOut)))); // R1

  AST_ALERT_PIN: assert property (@(posedge clk) disable iff (!rstN)
    (seen && $past(modeAlert)) |-> ((pinOe == $past(!enableN && alertReq)) && !pinOut)); // R2

  AST_ARM_BY_HOST: assert property (@(posedge clk) disable iff (!rstN)
    (seen && $fell(enableN)) |-> $past(enWrStb && !enWrData)); // R3

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (seen && $rose(sdaPullLow)) |-> !$past(sclSync)); // R10

endmodule

bind alert_responder alert_responder_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .modeAlert  (modeAlert),
  .gpOut      (gpOut),
  .alertReq   (alertReq),
  .enWrStb    (enWrStb),
  .enWrData   (enWrData),
  .enableN    (enableN),
  .pinOe      (pinOe),
  .pinOut     (pinOut),
  .sdaPullLow (sdaPullLow),
  .sclSync    (sclSync)
);

// File: tb/alert_responder_tb_top.sv
module alert_responder_tb_top;

  localparam int Q = 10;
  localparam logic [6:0] ADDR_DUT = 7'h12;
  localparam logic [6:0] ADDR_LO  = 7'h0B;
  localparam logic [6:0] ADDR_HI  = 7'h35;
  localparam logic [7:0] ARA_RD   = 8'h19;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic modeAlert = 1'b1;
  logic gpOut = 1'b0;
  logic enDat = 1'b1;
  logic [2:0] req = '0;
  logic [2:0] stb = '0;
  logic [2:0] pull, oe, out, enN;
  wire busSda = mSda & ~pull[0] & ~pull[1] & ~pull[2];

  int total = 0;
  int bad = 0;
  int r10Bad = 0;
  logic pullPrev = 1'b0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  alert_responder #(.OWN_ADDR(ADDR_DUT)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(busSda), .sdaPullLow(pull[0]),
    .modeAlert(modeAlert), .gpOut(gpOut), .alertReq(req[0]), .enWrStb(stb[0]),
    .enWrData(enDat), .enableN(enN[0]), .pinOe(oe[0]), .pinOut(out[0]));

  alert_responder #(.OWN_ADDR(ADDR_LO)) peerLo_i (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(busSda), .sdaPullLow(pull[1]),
    .modeAlert(modeAlert), .gpOut(gpOut), .alertReq(req[1]), .enWrStb(stb[1]),
    .enWrData(enDat), .enableN(enN[1]), .pinOe(oe[1]), .pinOut(out[1]));

  alert_responder #(.OWN_ADDR(ADDR_HI)) peerHi_i (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(busSda), .sdaPullLow(pull[2]),
    .modeAlert(modeAlert), .gpOut(gpOut), .alertReq(req[2]), .enWrStb(stb[2]),
    .enWrData(enDat), .enableN(enN[2]), .pinOe(oe[2]), .pinOut(out[2]));

  // R10 monitor: a new pull-down must never start while the raw clock is high
  always @(negedge clk) begin
    if (rstN && pull[0] && !pullPrev && mScl) r10Bad = r10Bad + 1;
    pullPrev = pull[0];
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeEn(input int idx, input logic val);
    @(negedge clk);
    enDat = val;
    stb[idx] = 1'b1;
    @(negedge clk);
    stb = '0;
    waitClk(2);
  endtask

  task automatic startC;
    mSda = 1'b1; mScl = 1'b1; waitClk(Q);
    mSda = 1'b0; waitClk(Q);
    mScl = 1'b0; waitClk(Q);
  endtask

  task automatic stopC;
    mSda = 1'b0; waitClk(Q);
    mScl = 1'b1; waitClk(Q);
    mSda = 1'b1; waitClk(Q);
  endtask

  task automatic sendBit(input logic b);
    mSda = b; waitClk(Q);
    mScl = 1'b1; waitClk(2 * Q);
    mScl = 1'b0; waitClk(Q);
  endtask

  task automatic readBit(output logic b);
    mSda = 1'b1; waitClk(Q);
    mScl = 1'b1; waitClk(Q);
    b = busSda; waitClk(Q);
    mScl = 1'b0; waitClk(Q);
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
  endtask

  task automatic readByte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
  endtask

  task automatic araTxn(input logic [7:0] hdr, output logic ack, output logic [7:0] d);
    d = 8'hFF;
    startC;
    sendByte(hdr);
    readBit(ack);
    if (!ack) begin
      readByte(d);
      sendBit(1'b1);
    end
    stopC;
    waitClk(4);
  endtask

  task automatic tReset;
    chk("R3 reset enableN dut", enN[0], 1);
    chk("R3 reset enableN peers", enN[2:1], 3);
    chk("R2 reset alert pin off", oe[0], 0);
    chk("R7 reset SDA released", pull, 0);
  endtask

  task automatic tPinMux;
    modeAlert = 1'b0; gpOut = 1'b1;
    writeEn(0, 1'b0);
    req[0] = 1'b1;
    waitClk(3);
    chk("R1 gp mode oe", oe[0], 1);
    chk("R1 gp mode level high", out[0], 1);
    gpOut = 1'b0; waitClk(2);
    chk("R1 gp mode level low with alert armed", out[0], 0);
    chk("R1 gp mode oe with alert armed", oe[0], 1);
    modeAlert = 1'b1; waitClk(2);
    chk("R2 armed request pulls pin", oe[0], 1);
    chk("R2 alert level", out[0], 0);
    chk("R3 host write cleared enableN", enN[0], 0);
    req[0] = 1'b0; waitClk(2);
    chk("R2 no request no pull", oe[0], 0);
    req[0] = 1'b1; waitClk(2);
    chk("R2 request back pulls pin", oe[0], 1);
  endtask

  task automatic tNotPending;
    logic ack;
    logic [7:0] d;
    writeEn(0, 1'b1);
    chk("R3 host write sets enableN", enN[0], 1);
    araTxn(ARA_RD, ack, d);
    chk("R7 no ack while not pending", ack, 1);
    chk("R7 enableN unchanged", enN[0], 1);
  endtask

  task automatic tWrongAddr;
    logic ack;
    logic [7:0] d;
    writeEn(0, 1'b0);
    araTxn(8'h18, ack, d);
    chk("R4 write-form byte not acked", ack, 1);
    araTxn(8'h1B, ack, d);
    chk("R4 other address not acked", ack, 1);
    chk("R4 alert kept after mismatch", oe[0], 1);
    chk("R4 enableN kept after mismatch", enN[0], 0);
  endtask

  task automatic tSingle;
    logic ack;
    logic [7:0] d;
    araTxn(ARA_RD, ack, d);
    chk("R4 alert response acked", ack, 0);
    chk("R5 own address returned", d[7:1], ADDR_DUT);
    chk("R5 eighth bit released", d[0], 1);
    chk("R6 enableN set after win", enN[0], 1);
    chk("R6 alert released", oe[0], 0);
    waitClk(50);
    chk("R6 stays released with request held", oe[0], 0);
    writeEn(0, 1'b0);
    chk("R6 rearmed by host", oe[0], 1);
  endtask

  task automatic tAbort;
    logic ack, b0, b1;
    logic [7:0] d;
    startC;
    sendByte(ARA_RD);
    readBit(ack);
    chk("R4 ack before abort", ack, 0);
    readBit(b0);
    readBit(b1);
    chk("R5 first bits of address", {b0, b1}, 0);
    stopC;
    waitClk(4);
    chk("R9 SDA released after STOP", pull[0], 0);
    chk("R9 enableN unchanged by aborted read", enN[0], 0);
    chk("R9 alert still raised", oe[0], 1);
    araTxn(ARA_RD, ack, d);
    chk("R9 fresh response after abort acked", ack, 0);
    chk("R9 fresh response address", d[7:1], ADDR_DUT);
    chk("R6 released after fresh response", enN[0], 1);
  endtask

  task automatic tArb;
    logic ack;
    logic [7:0] d;
    req = 3'b111;
    writeEn(0, 1'b0);
    writeEn(1, 1'b0);
    writeEn(2, 1'b0);
    chk("R2 all three alerting", oe, 7);
    araTxn(ARA_RD, ack, d);
    chk("R8 first round acked", ack, 0);
    chk("R8 lowest address wins", d[7:1], ADDR_LO);
    chk("R8 enable bits after round one", enN, 3'b010);
    chk("R8 losers keep alert", oe, 3'b101);
    araTxn(ARA_RD, ack, d);
    chk("R8 second round address", d[7:1], ADDR_DUT);
    chk("R8 enable bits after round two", enN, 3'b011);
    araTxn(ARA_RD, ack, d);
    chk("R8 third round address", d[7:1], ADDR_HI);
    chk("R8 all released", oe, 0);
    araTxn(ARA_RD, ack, d);
    chk("R7 nobody pending no ack", ack, 1);
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(4);
    tReset;
    tPinMux;
    tNotPending;
    tWrongAddr;
    tSingle;
    tAbort;
    tArb;
    chk("R10 pull-down started only with SCL low", r10Bad, 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule